// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous burst SRAM with a pipelined read path and a small internal array (64 words of 36 bits by default, split into four 9-bit lanes). Every control, address and write input is acted on at the rising clock edge. Two address strobes start accesses under different rules. The processor strobe is gated by the first chip select and always starts with a read. The controller strobe can write on its very first clock. Without a strobe, an open access either advances through a 4-beat wrapping burst or holds its address.

Read data leaves through an output register one clock after the address edge. A drive-enable output combines the registered cycle state with an asynchronous output-enable input. The bus is modelled as separate input data, output data and drive-enable ports. An asynchronous sleep input, synchronized over two clocks, freezes the block while keeping the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the block is deselected: `dout_en` is 0 and `dout` is all zeros.
- R2: A strobe starts an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A strobe that is honoured while any select is inactive deselects the block, and the bus goes to high impedance.
- R3: `pstb_n` low is ignored while `sel0_n` is high. Without `cstb_n` low, an open burst then continues as if no strobe were given.
- R4: When both strobes are low, the processor strobe wins, so the write inputs on that clock are ignored.
- R5: An access started by `pstb_n` is a read on its first clock. A write to that address needs a second clock with no strobe, `step_n`=1 and the write inputs active.
- R6: An access started by `cstb_n` with the write inputs active writes to `addr` on that same clock, whatever `step_n` shows.
- R7: `wr_all_n`=0 writes all four lanes. Otherwise, with `byte_wr_n`=0, each lane i whose `byte_sel_n[i]` is 0 takes `din[9i+8:9i]`. All other lanes keep their contents.
- R8: Data read at a clock edge appears on `dout`, with `dout_en`=1 when `out_ena_n`=0, after the following edge, provided that following edge is itself a read.
- R9: After any edge that performs a write, and after any edge that deselects, `dout_en` is 0 whatever `out_ena_n` shows.
- R10: In the cycle after the first read edge that follows a deselected state, `dout_en` is 0 even with `out_ena_n`=0. Afterwards `out_ena_n`=1 turns `dout_en` off at once, without waiting for a clock.
- R11: Burst beat i (i = 0..3) from start address a uses low bits a[1:0]+i mod 4 when `lin_order`=1, and a[1:0] XOR i when `lin_order`=0. The upper bits stay fixed. With no strobe, `step_n`=0 moves to the next beat and `step_n`=1 repeats the current one.
- R12: Two clocks after `doze` rises, all accesses are ignored and `dout_en` stays 0. The array keeps its contents, and the block wakes deselected two clocks after `doze` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| doze | input | 1 | Asynchronous active-high sleep request |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | 6 | Word address |
| sel0_n | input | 1 | Chip select, active low, also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write-all-lanes enable, active low |
| byte_wr_n | input | 1 | Lane-write enable, active low |
| byte_sel_n | input | 4 | Per-lane write selects, active low |
| out_ena_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Output register contents |
| dout_en | output | 1 | Bus drive enable |

## Verification
The array is first filled with global writes, which gives every word a known value. Directed sequences then separate the two strobes. One case pairs a processor strobe with active write inputs followed by a deselect, which shows that the first clock never writes. Another pairs a controller strobe with `step_n` low, which shows the write lands on `addr` and not on the next beat. Both strobes low together, and the processor strobe with `sel0_n` high in the middle of a burst, show which strobe is honoured. Lane masks such as 1010, and a global write with every lane select inactive, tell the two write paths apart. Linear and interleaved bursts from a start address with nonzero low bits show the wrap order. A mix of random lane writes and bursts of random length, order and start address then checks every returned word against a bench copy of the array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_DESEL = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          step_en,
  input  logic          linear,
  input  logic [CW-1:0] start_lo,
  output logic [CW-1:0] lo
);
  logic [CW-1:0] base_q, cnt_q, base_d, cnt_d;

  always_comb begin
    base_d = load ? start_lo : base_q;
    if (load)         cnt_d = '0;
    else if (advance) cnt_d = cnt_q + CW'(1);
    else              cnt_d = cnt_q;
    lo = linear ? (base_d + cnt_d) : (base_d ^ cnt_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES-1:0]    wr_lane,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane[g]) bank[wr_addr] <= wr_data[g*LW +: LW];
    end
    assign rd_data[g*LW +: LW] = bank[rd_addr];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pend,
  input  logic          keep,
  input  logic [DW-1:0] rd_data,
  input  logic          out_ena_n,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          load_d;
  logic          act_q;
  logic [DW-1:0] dout_q;

  assign load_d = rd_pend & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      act_q <= load_d;
      if (load_d) dout_q <= rd_data;
    end
  end

  assign dout    = dout_q;
  assign dout_en = act_q & ~out_ena_n;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    doze,
  input  logic                    lin_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        byte_sel_n,
  input  logic                    out_ena_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int UP_W   = ADDR_W - BURST_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // sleep request synchronizer: two clocks to enter or leave
  logic [1:0] doze_pipe;
  logic       sleeping;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) doze_pipe <= '0;
    else          doze_pipe <= {doze_pipe[0], doze};
  end
  assign sleeping = doze_pipe[1];

  // cycle decode
  logic              chip_on, p_hit, strobe, load, advance, wr_req, step_en;
  logic [LANES-1:0]  lane_mask, wr_lanes;
  cyc_e              cyc;
  logic              active_q, active_d;
  logic [UP_W-1:0]   up_q;
  logic [BURST_W-1:0] lo;
  logic [ADDR_W-1:0] acc_addr, rd_addr_q;
  logic              rd_v_q;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    chip_on = ~sel0_n & sel1 & ~sel2_n;
    p_hit   = ~pstb_n & ~sel0_n;
    strobe  = p_hit | ~cstb_n;
    if (!wr_all_n)       lane_mask = '1;
    else if (!byte_wr_n) lane_mask = ~byte_sel_n;
    else                 lane_mask = '0;
    wr_req = |lane_mask;

    if (sleeping)                   cyc = CYC_DESEL;
    else if (strobe && !chip_on)    cyc = CYC_DESEL;
    else if (strobe && p_hit)       cyc = CYC_READ;
    else if (strobe || active_q)    cyc = wr_req ? CYC_WRITE : CYC_READ;
    else                            cyc = CYC_NONE;

    load     = strobe & chip_on & ~sleeping;
    advance  = ~strobe & ~step_n;
    step_en  = (cyc == CYC_READ) | (cyc == CYC_WRITE);
    wr_lanes = (cyc == CYC_WRITE) ? lane_mask : '0;
    acc_addr = {(load ? addr[ADDR_W-1:BURST_W] : up_q), lo};
    active_d = step_en ? 1'b1 : ((cyc == CYC_DESEL) ? 1'b0 : active_q);
  end

  sbs_burst_ctr #(.CW(BURST_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .advance  (advance),
    .step_en  (step_en),
    .linear   (lin_order),
    .start_lo (addr[BURST_W-1:0]),
    .lo       (lo)
  );

  // access state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      active_q  <= 1'b0;
      up_q      <= '0;
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      active_q <= active_d;
      rd_v_q   <= (cyc == CYC_READ);
      if (load)              up_q      <= addr[ADDR_W-1:BURST_W];
      if (cyc == CYC_READ)   rd_addr_q <= acc_addr;
    end
  end

  sbs_mem_array #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_mem (
    .clk     (clk),
    .wr_addr (acc_addr),
    .wr_lane (wr_lanes),
    .wr_data (din),
    .rd_addr (rd_addr_q),
    .rd_data (rd_data)
  );

  sbs_out_stage #(.DW(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rd_pend   (rd_v_q),
    .keep      (cyc == CYC_READ),
    .rd_data   (rd_data),
    .out_ena_n (out_ena_n),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // assertions
  a_r9_wr_hiz: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc == CYC_WRITE) |=> !dout_en);
  a_r9_desel_hiz: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc == CYC_DESEL) |=> !dout_en);
  a_r10_first_hiz: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc == CYC_READ && !active_q) |=> !dout_en);
  a_r12_doze_hiz: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleeping |=> !dout_en);
  a_r5_pstb_reads: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!pstb_n && !sel0_n) |-> (wr_lanes == '0));
  a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc == CYC_READ && !strobe && step_n && rd_v_q) |-> (acc_addr == rd_addr_q));
endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, doze, lin_order, sel0_n, sel1, sel2_n, pstb_n, cstb_n, step_n;
  logic        wr_all_n, byte_wr_n, out_ena_n;
  logic [3:0]  byte_sel_n;
  logic [5:0]  addr;
  logic [35:0] din, dout;
  logic        dout_en;

  logic [35:0] ref_mem [64];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .doze(doze), .lin_order(lin_order), .addr(addr),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .byte_sel_n(byte_sel_n),
    .out_ena_n(out_ena_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] seq_addr(input logic [5:0] a, input int i, input bit lin);
    logic [1:0] o, s;
    o = i[1:0];
    s = lin ? (a[1:0] + o) : (a[1:0] ^ o);
    return {a[5:2], s};
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                        input logic wa_n, input logic bw_n, input logic [3:0] bs);
    logic [35:0] r;
    r = old;
    for (int l = 0; l < 4; l++)
      if (!wa_n || (!bw_n && !bs[l])) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] rnd36();
    return {4'($urandom()), $urandom()};
  endfunction

  task automatic idle();
    pstb_n = 1; cstb_n = 1; step_n = 1; wr_all_n = 1; byte_wr_n = 1; byte_sel_n = 4'hF;
    sel0_n = 0; sel1 = 1; sel2_n = 0;
  endtask

  task automatic desel();
    idle(); cstb_n = 0; sel1 = 0;
    tick();
    check(dout_en == 1'b0, "R9 deselect", {63'd0, dout_en}, 64'd0);
    idle();
  endtask

  task automatic check_data(input logic [5:0] a, input string req);
    check(dout_en === 1'b1 && dout === ref_mem[a], req, {27'd0, dout_en, dout}, {27'd0, 1'b1, ref_mem[a]});
  endtask

  // controller-strobe write; R6 R7 R9
  task automatic cwrite(input logic [5:0] a, input logic wa_n, input logic bw_n,
                        input logic [3:0] bs, input logic [35:0] d, input logic st_n);
    idle(); addr = a; cstb_n = 0; wr_all_n = wa_n; byte_wr_n = bw_n; byte_sel_n = bs;
    din = d; step_n = st_n;
    tick();
    check(dout_en == 1'b0, "R9 write hiz", {63'd0, dout_en}, 64'd0);
    ref_mem[a] = merge(ref_mem[a], d, wa_n, bw_n, bs);
    desel();
  endtask

  // burst read; R8 R10 R11
  task automatic burst(input logic [5:0] a, input int len, input bit lin);
    lin_order = lin;
    idle(); addr = a; cstb_n = 0;
    tick();
    check(dout_en == 1'b0, "R10 first read masked", {63'd0, dout_en}, 64'd0);
    idle();
    for (int i = 1; i < len; i++) begin
      step_n = 0;
      tick();
      check_data(seq_addr(a, i - 1, lin), "R8/R11 burst beat");
    end
    step_n = 1;
    tick();
    check_data(seq_addr(a, len - 1, lin), "R8/R11 last beat");
    step_n = 1;
    tick();
    check_data(seq_addr(a, len - 1, lin), "R11 suspend holds");
    desel();
  endtask

  initial begin
    logic [35:0] d;
    void'($urandom(32'd2024));
    rst_n = 0; doze = 0; lin_order = 1; out_ena_n = 0; addr = '0; din = '0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    check(dout_en == 1'b0 && dout == '0, "R1 reset state", {27'd0, dout_en, dout}, 64'd0);

    for (int a = 0; a < 64; a++) begin
      ref_mem[a] = '0;
      cwrite(6'(a), 1'b0, 1'b1, 4'hF, rnd36(), 1'b1);
    end

    // R11 orders
    burst(6'd6, 4, 1'b1);
    burst(6'd9, 4, 1'b0);

    // R7 lane writes and global override
    cwrite(6'd5, 1'b1, 1'b0, 4'b1010, rnd36(), 1'b1);
    burst(6'd5, 1, 1'b1);
    cwrite(6'd7, 1'b0, 1'b1, 4'hF, rnd36(), 1'b1);
    burst(6'd7, 1, 1'b1);
    cwrite(6'd9, 1'b1, 1'b1, 4'h0, rnd36(), 1'b1);
    burst(6'd9, 1, 1'b1);

    // R6 controller write ignores advance
    cwrite(6'd12, 1'b0, 1'b1, 4'hF, rnd36(), 1'b0);
    burst(6'd12, 2, 1'b1);

    // R5 processor strobe first clock is a read
    idle(); addr = 6'd20; pstb_n = 0; wr_all_n = 0; din = ~ref_mem[20];
    tick();
    check(dout_en == 1'b0, "R5 first clock no drive", {63'd0, dout_en}, 64'd0);
    desel();
    burst(6'd20, 1, 1'b1);
    idle(); addr = 6'd21; pstb_n = 0;
    tick();
    idle(); wr_all_n = 0; d = rnd36(); din = d;
    tick();
    check(dout_en == 1'b0, "R5/R9 second clock write", {63'd0, dout_en}, 64'd0);
    ref_mem[21] = d;
    desel();
    burst(6'd21, 1, 1'b1);

    // R4 priority of processor strobe
    idle(); addr = 6'd14; pstb_n = 0; cstb_n = 0; wr_all_n = 0; din = ~ref_mem[14];
    tick();
    desel();
    burst(6'd14, 1, 1'b1);

    // R3 processor strobe gated by sel0_n
    lin_order = 1;
    idle(); addr = 6'd32; cstb_n = 0;
    tick();
    idle(); pstb_n = 0; sel0_n = 1; step_n = 0; addr = 6'd50;
    tick();
    check_data(6'd32, "R3 burst continues");
    idle();
    tick();
    check_data(6'd33, "R3 next beat");
    desel();
    idle(); pstb_n = 0; sel0_n = 1; addr = 6'd40;
    tick();
    idle();
    tick();
    check(dout_en == 1'b0, "R3 ignored from idle", {63'd0, dout_en}, 64'd0);

    // R2 chip selects
    idle(); addr = 6'd3; cstb_n = 0; sel2_n = 1;
    tick();
    idle(); step_n = 0;
    tick();
    check(dout_en == 1'b0, "R2 no start without select", {63'd0, dout_en}, 64'd0);
    idle(); addr = 6'd8; cstb_n = 0;
    tick();
    idle();
    tick();
    check_data(6'd8, "R2 selected read");
    idle(); pstb_n = 0; sel1 = 0;
    tick();
    check(dout_en == 1'b0, "R2 strobe with inactive select", {63'd0, dout_en}, 64'd0);
    idle();

    // R10 asynchronous output enable
    idle(); addr = 6'd16; cstb_n = 0;
    tick();
    idle(); step_n = 0;
    tick();
    check_data(6'd16, "R10 driven");
    out_ena_n = 1; #1;
    check(dout_en == 1'b0, "R10 oe off", {63'd0, dout_en}, 64'd0);
    out_ena_n = 0; #1;
    check_data(6'd16, "R10 oe back on");
    desel();

    // R12 sleep
    idle(); doze = 1;
    tick(); tick();
    addr = 6'd3; cstb_n = 0; wr_all_n = 0; din = ~ref_mem[3];
    tick();
    check(dout_en == 1'b0, "R12 asleep", {63'd0, dout_en}, 64'd0);
    idle(); cstb_n = 0; addr = 6'd3;
    tick();
    idle();
    tick();
    check(dout_en == 1'b0, "R12 read ignored asleep", {63'd0, dout_en}, 64'd0);
    doze = 0;
    tick(); tick();
    check(dout_en == 1'b0, "R12 wake hiz", {63'd0, dout_en}, 64'd0);
    burst(6'd3, 1, 1'b1);

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [5:0] a;
      a = 6'($urandom() % 64);
      if ($urandom() % 3 == 0)
        cwrite(a, 1'($urandom()), 1'($urandom()), 4'($urandom()), rnd36(), 1'($urandom()));
      else
        burst(a, 1 + int'($urandom() % 4), 1'($urandom()));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule